// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed. A free-running interval timer marks each point at which a refresh falls due and adds it to a count of owed refreshes. While any refresh is owed, the block asks the main controller for the command bus. It asks an external precharge unit to close every bank and then drives the auto-refresh command with CKE high. No row address is needed, because the device uses its internal row counter.

The same block also runs the low-power path. When the system asks for self-refresh and the read data path has drained, it takes the bus and closes the banks in the same way. It then issues the refresh command in the same cycle that it pulls CKE low, and keeps CKE low for as long as the request stays up. When the request drops, it raises CKE and holds it for the clock-stable time. It then leaves a full row-cycle window with only NOP/DESL on the bus and issues a catch-up refresh. In burst mode a programmable batch of back-to-back refreshes is issued both before entry and after exit. Clock frequency and all timing values are parameters given in nanoseconds and converted to cycles by rounding up, with at least one cycle.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ref_req, pre_req, cmd_ref and ref_urgent are 0 and cke is 1.
- R2: Every REFI cycles the interval timer adds one owed refresh. While at least one is owed, the block raises ref_req from idle on the next cycle.
- R3: pre_req is high only while ref_req and ref_gnt are both high. No refresh command (cmd_ref=1) is driven until ref_gnt and pre_done have been high together.
- R4: An auto-refresh is a single-cycle cmd_ref=1 pulse with cke=1 (cmd_ref=0 means NOP/DESL). The bus is then held for the rest of an RFC-cycle window before ref_req is released, and the owed count drops by one.
- R5: The owed count saturates at MAX_PEND. ref_urgent is 1 whenever the count is at least URGENT_MISSES, and it falls once the backlog is served.
- R6: Self-refresh entry starts only from idle with sr_req=1 and rd_idle=1. It uses the same grant/precharge handshake, and the entry cycle drives cmd_ref=1 with cke=0.
- R7: After entry, cke stays 0 and cmd_ref stays 0 for as long as sr_req is 1.
- R8: When sr_req falls, cke returns to 1 and the next cmd_ref comes exactly CKSP+RC cycles after the first cycle with cke high. Only NOP/DESL is driven in between.
- R9: With burst_mode=1 sampled at the start of a self-refresh request, BURST_REFS refreshes spaced RFC cycles apart precede entry, and BURST_REFS follow exit. With burst_mode=0 there are none before entry and one after exit.
- R10: Self-refresh entry clears the owed count, and interval ticks from entry until the return to idle are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| rd_idle | input | 1 | Last read data has left the data bus |
| burst_mode | input | 1 | Use a batch of refreshes around self-refresh |
| ref_gnt | input | 1 | Controller hands the command bus to this block |
| pre_done | input | 1 | All banks are precharged |
| ref_req | output | 1 | Bus request, held for the whole sequence |
| pre_req | output | 1 | Ask the precharge unit to close all banks |
| ref_urgent | output | 1 | Owed refreshes reached the urgency threshold |
| cmd_ref | output | 1 | 1 = refresh command this cycle, 0 = NOP/DESL |
| cke | output | 1 | Clock-enable level for the device |

## Verification
The main function is driven with several input patterns. In the first, the grant is withheld across many intervals, which separates a saturating backlog with urgency from one refresh per interval. In the second, the grant and the precharge-done flag are raised one at a time, which shows that neither alone lets a refresh out. Self-refresh is first requested while read data is still in flight, to tell a waiting entry from a premature one. It is then run once without and once with burst mode, which separates the single catch-up refresh from the batched ones and measures the exit gap in cycles. A behavioural reference model runs alongside and checks every output on every cycle.

// File: rtl/sdram_rs_pkg.sv
// Shared types and helpers for the refresh sequencer.
// Assumes timing values are given in ns and the clock in whole MHz.
package sdram_rs_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_REQ_PRE,
        RS_AUTO_REF,
        RS_SELF_ENTER,
        RS_SELF_HOLD,
        RS_EXIT_CKSP,
        RS_EXIT_TRC,
        RS_POST_REF
    } rs_state_t;

    // Round a nanosecond value up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdram_rs_refi_timer.sv
// Free-running refresh interval timer.
// Emits a one-cycle tick every PERIOD cycles; the first tick follows reset by PERIOD cycles.
module sdram_rs_refi_timer #(
    parameter int PERIOD = 1563
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    // Wrap the counter at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + W'(1);
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sdram_rs_debt.sv
// Count of refreshes that fell due and are not yet served.
// Saturates at MAX_PEND; a clear wins over increment and decrement.
module sdram_rs_debt #(
    parameter int MAX_PEND      = 8,
    parameter int URGENT_MISSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic nonzero,
    output logic urgent
);
    localparam int W = $clog2(MAX_PEND + 1);
    localparam logic [W-1:0] MAXV = W'(MAX_PEND);

    logic [W-1:0] pend_q;

    // Track owed refreshes with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (pend_q != MAXV) pend_q <= pend_q + W'(1);
                2'b01:   if (pend_q != '0)   pend_q <= pend_q - W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign nonzero = (pend_q != '0);
    assign urgent  = (32'(pend_q) >= 32'(URGENT_MISSES));
endmodule

// File: rtl/sdram_rs_down_timer.sv
// Loadable down-counter for one timed state.
// On load it takes LOAD_VAL and counts down to zero, where it rests.
module sdram_rs_down_timer #(
    parameter int LOAD_VAL = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int W = $clog2(LOAD_VAL + 1) + 1;

    logic [W-1:0] cnt_q;

    // Load on request, otherwise step down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= W'(LOAD_VAL);
        else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_seq.sv
// Refresh and self-refresh sequencer for an SDRAM command bus.
// Assumes the controller keeps ref_gnt high for as long as ref_req is high,
// and that the precharge unit holds pre_done while all banks stay closed.
module sdram_refresh_seq
    import sdram_rs_pkg::*;
#(
    parameter int CLK_MHZ       = 100,
    parameter int REFI_NS       = 15625,
    parameter int RFC_NS        = 70,
    parameter int CKSP_NS       = 20,
    parameter int RC_NS         = 70,
    parameter int BURST_REFS    = 4096,
    parameter int MAX_PEND      = 8,
    parameter int URGENT_MISSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic rd_idle,
    input  logic burst_mode,
    input  logic ref_gnt,
    input  logic pre_done,
    output logic ref_req,
    output logic pre_req,
    output logic ref_urgent,
    output logic cmd_ref,
    output logic cke
);
    localparam int REFI_CYC = ns_to_cyc(REFI_NS, CLK_MHZ);
    localparam int RFC_CYC  = ns_to_cyc(RFC_NS, CLK_MHZ);
    localparam int CKSP_CYC = ns_to_cyc(CKSP_NS, CLK_MHZ);
    localparam int RC_CYC   = ns_to_cyc(RC_NS, CLK_MHZ);
    localparam int BW       = $clog2(BURST_REFS + 1);
    localparam logic [BW-1:0] BURST_LD = BW'(BURST_REFS);

    rs_state_t       state_q, state_d;
    logic            sr_mode_q, sr_mode_d;
    logic            bsel_q, bsel_d;
    logic [BW-1:0]   pre_left_q, pre_left_d;
    logic [BW-1:0]   post_left_q, post_left_d;
    logic            rfc_fresh_q;

    logic tick, owed, in_sr_region;
    logic rfc_load, cksp_load, trc_load;
    logic rfc_zero, cksp_zero, trc_zero;
    logic debt_dec, debt_clr, debt_inc;

    sdram_rs_refi_timer #(.PERIOD(REFI_CYC)) u_refi (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sdram_rs_debt #(.MAX_PEND(MAX_PEND), .URGENT_MISSES(URGENT_MISSES)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (debt_inc),
        .dec     (debt_dec),
        .clr     (debt_clr),
        .nonzero (owed),
        .urgent  (ref_urgent)
    );

    sdram_rs_down_timer #(.LOAD_VAL(RFC_CYC - 1)) u_rfc_tmr (
        .clk (clk), .rst_n (rst_n), .load (rfc_load), .zero (rfc_zero)
    );

    sdram_rs_down_timer #(.LOAD_VAL(CKSP_CYC - 1)) u_cksp_tmr (
        .clk (clk), .rst_n (rst_n), .load (cksp_load), .zero (cksp_zero)
    );

    sdram_rs_down_timer #(.LOAD_VAL(RC_CYC - 1)) u_trc_tmr (
        .clk (clk), .rst_n (rst_n), .load (trc_load), .zero (trc_zero)
    );

    assign in_sr_region = state_q inside {RS_SELF_ENTER, RS_SELF_HOLD, RS_EXIT_CKSP,
                                          RS_EXIT_TRC, RS_POST_REF};
    assign debt_inc = tick && !in_sr_region;
    assign debt_clr = (state_q == RS_SELF_ENTER);

    // Next-state, timer loads and batch counters of the sequencer.
    always_comb begin
        state_d     = state_q;
        sr_mode_d   = sr_mode_q;
        bsel_d      = bsel_q;
        pre_left_d  = pre_left_q;
        post_left_d = post_left_q;
        rfc_load    = 1'b0;
        cksp_load   = 1'b0;
        trc_load    = 1'b0;
        debt_dec    = 1'b0;
        case (state_q)
            RS_IDLE: begin
                if (sr_req && rd_idle) begin
                    state_d    = RS_REQ_PRE;
                    sr_mode_d  = 1'b1;
                    bsel_d     = burst_mode;
                    pre_left_d = burst_mode ? BURST_LD : '0;
                end else if (owed) begin
                    state_d   = RS_REQ_PRE;
                    sr_mode_d = 1'b0;
                end
            end
            RS_REQ_PRE: begin
                if (ref_gnt && pre_done) begin
                    if (sr_mode_q && pre_left_q == '0) begin
                        state_d = RS_SELF_ENTER;
                    end else begin
                        state_d  = RS_AUTO_REF;
                        rfc_load = 1'b1;
                    end
                end
            end
            RS_AUTO_REF: begin
                if (rfc_zero) begin
                    debt_dec = 1'b1;
                    if (sr_mode_q) begin
                        pre_left_d = pre_left_q - BW'(1);
                        if (pre_left_q > BW'(1)) rfc_load = 1'b1;
                        else                     state_d  = RS_SELF_ENTER;
                    end else begin
                        state_d = RS_IDLE;
                    end
                end
            end
            RS_SELF_ENTER: state_d = RS_SELF_HOLD;
            RS_SELF_HOLD: begin
                if (!sr_req) begin
                    state_d   = RS_EXIT_CKSP;
                    cksp_load = 1'b1;
                end
            end
            RS_EXIT_CKSP: begin
                if (cksp_zero) begin
                    state_d  = RS_EXIT_TRC;
                    trc_load = 1'b1;
                end
            end
            RS_EXIT_TRC: begin
                if (trc_zero) begin
                    state_d     = RS_POST_REF;
                    rfc_load    = 1'b1;
                    post_left_d = bsel_q ? BURST_LD : BW'(1);
                end
            end
            RS_POST_REF: begin
                if (rfc_zero) begin
                    if (post_left_q > BW'(1)) begin
                        post_left_d = post_left_q - BW'(1);
                        rfc_load    = 1'b1;
                    end else begin
                        state_d = RS_IDLE;
                    end
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Sequencer state and batch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RS_IDLE;
            sr_mode_q   <= 1'b0;
            bsel_q      <= 1'b0;
            pre_left_q  <= '0;
            post_left_q <= '0;
            rfc_fresh_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            sr_mode_q   <= sr_mode_d;
            bsel_q      <= bsel_d;
            pre_left_q  <= pre_left_d;
            post_left_q <= post_left_d;
            rfc_fresh_q <= rfc_load;
        end
    end

    assign ref_req = (state_q != RS_IDLE);
    assign pre_req = (state_q == RS_REQ_PRE) && ref_gnt;
    assign cke     = !(state_q == RS_SELF_ENTER || state_q == RS_SELF_HOLD);
    assign cmd_ref = (state_q == RS_SELF_ENTER) ||
                     ((state_q == RS_AUTO_REF || state_q == RS_POST_REF) && rfc_fresh_q);
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
// Property checker for the refresh sequencer, attached by bind.
// Assumes GAP is the exit window in cycles (clock-stable plus row cycle).
module sdram_refresh_seq_chk #(
    parameter int GAP     = 6,
    parameter int RFC_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic sr_req,
    input logic ref_gnt,
    input logic ref_req,
    input logic pre_req,
    input logic ref_urgent,
    input logic cmd_ref,
    input logic cke
);
    logic        cke_q;
    logic        armed_q;
    logic [31:0] gap_q;

    // Count cycles from the CKE rise to the first refresh after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q   <= 1'b1;
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else begin
            cke_q <= cke;
            if (cke && !cke_q) begin
                armed_q <= 1'b1;
                gap_q   <= 32'd1;
            end else if (armed_q) begin
                gap_q <= gap_q + 32'd1;
                if (cmd_ref) armed_q <= 1'b0;
            end
        end
    end

    p_pre_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> (ref_req && ref_gnt));
    p_ref_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> ref_req);
    p_ref_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((RFC_CYC > 1) && cmd_ref && cke) |=> !cmd_ref);
    p_urgent_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !ref_req) |=> ref_req);
    p_enter_with_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> cmd_ref);
    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && sr_req) |=> !cke);
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$fell(cke)) |-> !cmd_ref);
    p_exit_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_ref);
    p_exit_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cmd_ref) |-> (gap_q == 32'(GAP)));
    p_debt_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |=> !ref_urgent);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
    .GAP     (CKSP_CYC + RC_CYC),
    .RFC_CYC (RFC_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_req     (sr_req),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .pre_req    (pre_req),
    .ref_urgent (ref_urgent),
    .cmd_ref    (cmd_ref),
    .cke        (cke)
);

// File: tb/tb_sdram_refresh_seq.sv
// Bench for the refresh sequencer: a behavioural reference model checked every cycle,
// plus scenario checks tied to the requirements.
module tb_sdram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T_REFI = 40;
    localparam int T_RFC  = 3;
    localparam int T_CKSP = 2;
    localparam int T_RC   = 4;
    localparam int NBURST = 3;
    localparam int NMAX   = 7;
    localparam int NURG   = 3;

    logic clk = 1'b0;
    logic rst_n, sr_req, rd_idle, burst_mode, ref_gnt, pre_done;
    logic ref_req, pre_req, ref_urgent, cmd_ref, cke;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_refresh_seq #(
        .CLK_MHZ(100), .REFI_NS(400), .RFC_NS(30), .CKSP_NS(20), .RC_NS(40),
        .BURST_REFS(NBURST), .MAX_PEND(NMAX), .URGENT_MISSES(NURG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .rd_idle(rd_idle),
        .burst_mode(burst_mode), .ref_gnt(ref_gnt), .pre_done(pre_done),
        .ref_req(ref_req), .pre_req(pre_req), .ref_urgent(ref_urgent),
        .cmd_ref(cmd_ref), .cke(cke)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model: phase 0 idle, 1 request, 2 refresh, 3 enter, 4 hold,
    // 5 clock-stable wait, 6 row-cycle wait, 7 catch-up refresh.
    int m_ph, m_left, m_owed, m_tc, m_bl, m_pl;
    bit m_sr, m_bsel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_owed = 0; m_tc = 0;
            m_bl = 0; m_pl = 0; m_sr = 0; m_bsel = 0;
        end else begin
            bit tk;
            int old_owed;
            old_owed = m_owed;
            tk = (m_tc == T_REFI - 1);
            m_tc = tk ? 0 : m_tc + 1;
            if (m_ph == 3) m_owed = 0;
            else begin
                bit up, dn;
                up = tk && (m_ph < 3);
                dn = (m_ph == 2) && (m_left == 1);
                if (up && !dn && m_owed < NMAX) m_owed++;
                if (dn && !up && m_owed > 0)    m_owed--;
            end
            case (m_ph)
                0: if (sr_req && rd_idle) begin
                       m_ph = 1; m_sr = 1; m_bsel = burst_mode;
                       m_bl = burst_mode ? NBURST : 0;
                   end else if (old_owed > 0) begin
                       m_ph = 1; m_sr = 0;
                   end
                1: if (ref_gnt && pre_done) begin
                       if (m_sr && m_bl == 0) m_ph = 3;
                       else begin m_ph = 2; m_left = T_RFC; end
                   end
                2: if (m_left > 1) m_left--;
                   else if (m_sr) begin
                       m_bl--;
                       if (m_bl > 0) m_left = T_RFC; else m_ph = 3;
                   end else m_ph = 0;
                3: m_ph = 4;
                4: if (!sr_req) begin m_ph = 5; m_left = T_CKSP; end
                5: if (m_left > 1) m_left--; else begin m_ph = 6; m_left = T_RC; end
                6: if (m_left > 1) m_left--;
                   else begin m_ph = 7; m_left = T_RFC; m_pl = m_bsel ? NBURST : 1; end
                7: if (m_left > 1) m_left--;
                   else if (m_pl > 1) begin m_pl--; m_left = T_RFC; end
                   else m_ph = 0;
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "ref_req vs model", int'(ref_req), int'(m_ph != 0));
            chk("R3", "pre_req vs model", int'(pre_req), int'(m_ph == 1 && ref_gnt));
            chk("R5", "ref_urgent vs model", int'(ref_urgent), int'(m_owed >= NURG));
            chk("R7", "cke vs model", int'(cke), int'(!(m_ph == 3 || m_ph == 4)));
            chk("R4", "cmd_ref vs model", int'(cmd_ref),
                int'(m_ph == 3 || ((m_ph == 2 || m_ph == 7) && m_left == T_RFC)));
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog run did not finish act=1 exp=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Measure an exit: cycles from the CKE rise to the first refresh, then refreshes until idle.
    task automatic measure_exit(input int exp_posts);
        int k, n, lim;
        lim = 0;
        while (!cke && lim < 2000) begin @(negedge clk); lim++; end
        k = 0;
        while (!cmd_ref && k < 2000) begin @(negedge clk); k++; end
        chk("R8", "exit gap in cycles", k, T_CKSP + T_RC);
        n = 1;
        lim = 0;
        while (ref_req && lim < 2000) begin
            @(negedge clk); lim++;
            if (ref_req && cmd_ref) n++;
        end
        chk("R9", "refreshes after exit", n, exp_posts);
    endtask

    initial begin
        int n, m, lim;
        rst_n = 1'b0; sr_req = 1'b0; rd_idle = 1'b1; burst_mode = 1'b0;
        ref_gnt = 1'b0; pre_done = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ref_req after reset", int'(ref_req), 0);
        chk("R1", "pre_req after reset", int'(pre_req), 0);
        chk("R1", "cmd_ref after reset", int'(cmd_ref), 0);
        chk("R1", "ref_urgent after reset", int'(ref_urgent), 0);
        chk("R1", "cke after reset", int'(cke), 1);

        // Backlog with no grant: saturation and urgency.
        repeat (330) @(negedge clk);
        chk("R2", "request raised by owed refresh", int'(ref_req), 1);
        chk("R5", "urgent with large backlog", int'(ref_urgent), 1);

        // Precharge done alone must not release a refresh.
        @(posedge clk); #1 pre_done = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R3", "no pre_req without grant", int'(pre_req), 0);
            chk("R3", "no refresh without grant", int'(cmd_ref), 0);
        end
        // Grant alone: precharge asked, still no refresh.
        @(posedge clk); #1 ref_gnt = 1'b1; pre_done = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R3", "pre_req with grant", int'(pre_req), 1);
            chk("R3", "no refresh before precharge done", int'(cmd_ref), 0);
        end
        @(posedge clk); #1 pre_done = 1'b1;
        n = 0;
        repeat (60) begin
            @(negedge clk);
            if (cmd_ref) begin
                n++;
                chk("R4", "auto-refresh with cke high", int'(cke), 1);
            end
        end
        chk("R4", "backlog drained (at least 7)", int'(n >= NMAX), 1);
        chk("R5", "urgent cleared after drain", int'(ref_urgent), 0);

        // Self-refresh requested while reads are still in flight.
        @(posedge clk); #1 rd_idle = 1'b0; sr_req = 1'b1;
        n = 0;
        repeat (20) begin @(negedge clk); if (!cke) n++; end
        chk("R6", "no entry while reads pending", n, 0);
        @(posedge clk); #1 rd_idle = 1'b1;
        lim = 0;
        do begin @(negedge clk); lim++; end while (cke && lim < 2000);
        chk("R6", "entry drives refresh with cke low", int'(cmd_ref), 1);
        n = 0; m = 0;
        repeat (100) begin
            @(negedge clk);
            if (cmd_ref) n++;
            if (cke) m++;
        end
        chk("R7", "no refresh during hold", n, 0);
        chk("R7", "cke low during hold", m, 0);
        @(posedge clk); #1 sr_req = 1'b0;
        measure_exit(1);

        // First idle cycle: request self-refresh in burst mode.
        sr_req = 1'b1; burst_mode = 1'b1;
        n = 0; lim = 0;
        do begin
            @(negedge clk); lim++;
            if (cmd_ref && cke) n++;
        end while (cke && lim < 2000);
        chk("R9", "burst refreshes before entry", n, NBURST);
        chk("R6", "burst entry drives refresh with cke low", int'(cmd_ref), 1);
        repeat (50) @(negedge clk);
        @(posedge clk); #1 sr_req = 1'b0; burst_mode = 1'b0;
        measure_exit(NBURST);
        chk("R10", "no urgency after self-refresh", int'(ref_urgent), 0);
        @(negedge clk);
        chk("R10", "no owed refresh carried through self-refresh", int'(ref_req), 0);

        repeat (80) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule